// File: doc/BRIEF.md
# I2C Byte-Pair Data Buffer

This block sits between a 16-bit software data register and a byte-serial I2C shifter. Each data register access moves two bus bytes at once. A transfer is launched with a direction and a byte count. On transmit, the block splits each written word into bytes for the shifter. On receive, it packs the bytes it gets from the shifter back into words.

The block raises a transmit request when it needs the next word and a receive request when a packed word is waiting to be read. A down-counter of the remaining bytes decides when the transfer ends, and the block then signals access-ready. It also flags two faults. A receive overrun is raised when a word completes while the previous one is still unread. A transmit underflow is raised when the shifter asks for a byte and no word has been written. The shifter talks to the block through a valid/ready pair in each direction. The bit-level SCL/SDA signalling is not part of this block.

Top module: `i2cbp_buffer`

## Requirements
- R1: After reset, `busy_o`, `tx_req_o`, `rx_req_o`, `acc_rdy_o`, `overrun_o`, `underflow_o`, `txb_valid_o` and `rxb_ready_o` are all 0, and `rd_data_o` is 16'h0000.
- R2: A start pulse with a count of zero is ignored. A start pulse while `busy_o` is 1 is ignored. A start with a count of 1 or more sets `busy_o` on the next clock edge. `start_tx_i` = 1 selects transmit and 0 selects receive.
- R3: On transmit, the bytes of each written word go to the shifter with bits 7:0 first and bits 15:8 second. A byte is handed over on a clock edge where `txb_valid_o` and `txb_ready_i` are both 1.
- R4: On transmit with an odd count, only bits 7:0 of the final word are sent. Exactly `count_i` bytes are offered in total, and after the last one `txb_valid_o` stays 0.
- R5: `tx_req_o` rises one edge after a transmit start. It rises again on the edge that takes the last byte of a word, as long as bytes remain. A data write while `tx_req_o` is 1 loads the word and clears the request. A write while it is 0 is ignored and does not change the bytes sent.
- R6: On receive, the first byte of a pair lands in bits 15:0's low half (bits 7:0) and the second in bits 15:8. `rx_req_o` is then set on the edge that takes the second byte. A read pulse (`rd_en_i`) clears `rx_req_o`.
- R7: On receive with an odd count, the final byte is delivered alone in bits 7:0, with bits 15:8 reading as zero, and `rx_req_o` is set.
- R8: If a receive word completes while `rx_req_o` is 1 and no read happens on that edge, `overrun_o` is set. The unread word on `rd_data_o` is kept unchanged.
- R9: During a transmit, an edge where `txb_ready_i` is 1 and no byte of a written word is pending sets `underflow_o`.
- R10: On the edge that hands over the last counted byte, `busy_o` clears and `acc_rdy_o` sets. `acc_rdy_o` stays set until the next accepted start.
- R11: The remaining count drops by exactly one per byte handed over. When idle, `rxb_ready_o` is 0, and bytes offered by the shifter then have no effect on `rx_req_o` or `rd_data_o`.
- R12: An accepted start clears `overrun_o`, `underflow_o`, `acc_rdy_o` and `rx_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse for a transfer |
| start_tx_i | input | 1 | Direction at launch: 1 transmit, 0 receive |
| count_i | input | CNT_W | Byte count at launch |
| wr_en_i | input | 1 | Data register write strobe |
| wr_data_i | input | 16 | Word written by software (bits 7:0 go first) |
| rd_en_i | input | 1 | Data register read strobe |
| rd_data_o | output | 16 | Last packed receive word |
| tx_req_o | output | 1 | Transmit word request |
| rx_req_o | output | 1 | Receive word available |
| acc_rdy_o | output | 1 | Count exhausted |
| overrun_o | output | 1 | Receive overrun, sticky until next start |
| underflow_o | output | 1 | Transmit underflow, sticky until next start |
| busy_o | output | 1 | Transfer in progress |
| txb_valid_o | output | 1 | Byte offered to the shifter |
| txb_ready_i | input | 1 | Shifter takes the offered byte |
| txb_data_o | output | 8 | Byte to the shifter |
| rxb_valid_i | input | 1 | Shifter offers a received byte |
| rxb_ready_o | output | 1 | Block accepts received bytes |
| rxb_data_i | input | 8 | Received byte from the shifter |

## Verification
The hardest situation to reach is a receive overrun that must leave the earlier word intact. It needs a word to be completed, left unread, and then a second pair to finish while the request is still high. The bench gets there by feeding a four-byte receive without issuing any read, then checks that the flag is set and that the data output still holds the first pair. Counts from one to twelve in both directions are swept. This covers every mix of full and half final words, and each byte value is computed arithmetically from its count and position.

// File: rtl/i2cbp_pkg.sv
package i2cbp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic {
        XFER_RX = 1'b0,
        XFER_TX = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } byte_pair_t;

    // Number of bytes a freshly loaded word will carry
    function automatic logic [1:0] word_fill(input logic more_than_one);
        return more_than_one ? 2'd2 : 2'd1;
    endfunction

    // Word produced by the receive packer
    function automatic byte_pair_t pack_pair(input logic have_low,
                                             input logic [BYTE_W-1:0] low_byte,
                                             input logic [BYTE_W-1:0] new_byte);
        byte_pair_t w;
        if (have_low) begin
            w.lo = low_byte;
            w.hi = new_byte;
        end else begin
            w.lo = new_byte;
            w.hi = '0;
        end
        return w;
    endfunction

endpackage

// File: rtl/i2cbp_ctrl.sv
module i2cbp_ctrl
    import i2cbp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  xfer_dir_e        dir_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             byte_done_i,
    output logic             launch_o,
    output logic             busy_o,
    output xfer_dir_e        dir_o,
    output logic             multi_o,
    output logic             last_o,
    output logic             ardy_o
);

    logic             busy_q;
    xfer_dir_e        dir_q;
    logic [CNT_W-1:0] remain_q;
    logic             ardy_q;

    assign launch_o = start_i && !busy_q && (count_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            dir_q    <= XFER_RX;
            remain_q <= '0;
            ardy_q   <= 1'b0;
        end else if (launch_o) begin
            busy_q   <= 1'b1;
            dir_q    <= dir_i;
            remain_q <= count_i;
            ardy_q   <= 1'b0;
        end else if (busy_q && byte_done_i) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                ardy_q <= 1'b1;
            end
        end
    end

    assign busy_o  = busy_q;
    assign dir_o   = dir_q;
    assign multi_o = (remain_q > CNT_W'(1));
    assign last_o  = (remain_q == CNT_W'(1));
    assign ardy_o  = ardy_q;

    // R2: zero-count start leaves the block idle
    a_r2_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && count_i == '0) |=> !busy_q);

    // R10: end of a transfer always raises access-ready
    a_r10_end_ardy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ardy_q);

    // R11: one count step per byte
    a_r11_decrement: assert property (@(posedge clk) disable iff (rst)
        (busy_q && byte_done_i && remain_q > CNT_W'(1) && !launch_o)
            |=> (remain_q == $past(remain_q) - 1'b1));

endmodule

// File: rtl/i2cbp_tx.sv
module i2cbp_tx
    import i2cbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic              launch_tx_i,
    input  logic              active_i,
    input  logic              multi_i,
    input  logic              wr_en_i,
    input  byte_pair_t        wr_data_i,
    input  logic              sh_ready_i,
    output logic              sh_valid_o,
    output logic [BYTE_W-1:0] sh_byte_o,
    output logic              xrdy_o,
    output logic              udf_o,
    output logic              done_o
);

    byte_pair_t word_q;
    logic [1:0] fill_q;
    logic       xrdy_q;
    logic       udf_q;
    logic       take;
    logic       load;

    assign sh_valid_o = (fill_q != 2'd0);
    assign sh_byte_o  = word_q.lo;
    assign take       = sh_valid_o && sh_ready_i;
    assign load       = wr_en_i && xrdy_q && active_i;
    assign done_o     = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            fill_q <= 2'd0;
            xrdy_q <= 1'b0;
            udf_q  <= 1'b0;
        end else if (launch_i) begin
            fill_q <= 2'd0;
            xrdy_q <= launch_tx_i;
            udf_q  <= 1'b0;
        end else begin
            if (load) begin
                word_q <= wr_data_i;
                fill_q <= word_fill(multi_i);
                xrdy_q <= 1'b0;
            end else if (take) begin
                word_q <= '{hi: '0, lo: word_q.hi};
                fill_q <= fill_q - 2'd1;
                if (fill_q == 2'd1 && multi_i)
                    xrdy_q <= 1'b1;
            end
            if (active_i && sh_ready_i && fill_q == 2'd0)
                udf_q <= 1'b1;
        end
    end

    assign xrdy_o = xrdy_q;
    assign udf_o  = udf_q;

    // R5: a pending request never coexists with a loaded byte
    a_r5_req_excl: assert property (@(posedge clk) disable iff (rst)
        !(xrdy_q && sh_valid_o));

    // R11: no byte is offered outside an active transmit
    a_r11_tx_idle: assert property (@(posedge clk) disable iff (rst)
        sh_valid_o |-> active_i);

    // R3: the second byte offered is the upper half of the loaded word
    a_r3_hi_second: assert property (@(posedge clk) disable iff (rst)
        (take && fill_q == 2'd2 && !launch_i) |=> (sh_byte_o == $past(word_q.hi)));

endmodule

// File: rtl/i2cbp_rx.sv
module i2cbp_rx
    import i2cbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic              active_i,
    input  logic              last_i,
    input  logic              sh_valid_i,
    input  logic [BYTE_W-1:0] sh_byte_i,
    input  logic              rd_en_i,
    output logic              sh_ready_o,
    output byte_pair_t        rd_word_o,
    output logic              rrdy_o,
    output logic              ovr_o,
    output logic              done_o
);

    logic [BYTE_W-1:0] lo_q;
    logic              half_q;
    byte_pair_t        word_q;
    logic              rrdy_q;
    logic              ovr_q;
    logic              take;
    logic              complete;

    assign sh_ready_o = active_i;
    assign take       = sh_valid_i && active_i;
    assign complete   = take && (half_q || last_i);
    assign done_o     = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            half_q <= 1'b0;
            word_q <= '0;
            rrdy_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (launch_i) begin
            half_q <= 1'b0;
            rrdy_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (take && !complete) begin
                lo_q   <= sh_byte_i;
                half_q <= 1'b1;
            end
            if (complete) begin
                half_q <= 1'b0;
                if (rrdy_q && !rd_en_i) begin
                    ovr_q <= 1'b1;
                end else begin
                    word_q <= pack_pair(half_q, lo_q, sh_byte_i);
                    rrdy_q <= 1'b1;
                end
            end else if (rd_en_i) begin
                rrdy_q <= 1'b0;
            end
        end
    end

    assign rd_word_o = word_q;
    assign rrdy_o    = rrdy_q;
    assign ovr_o     = ovr_q;

    // R6: a receive request only appears after a byte was taken
    a_r6_req_source: assert property (@(posedge clk) disable iff (rst)
        $rose(rrdy_q) |-> $past(take));

    // R8: the unread word survives an overrun
    a_r8_word_kept: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $stable(word_q));

    // R11: idle block takes nothing
    a_r11_rx_idle: assert property (@(posedge clk) disable iff (rst)
        (!active_i && !launch_i) |=> $stable(word_q));

endmodule

// File: rtl/i2cbp_buffer.sv
module i2cbp_buffer
    import i2cbp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             start_tx_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_en_i,
    input  logic [15:0]      wr_data_i,
    input  logic             rd_en_i,
    output logic [15:0]      rd_data_o,
    output logic             tx_req_o,
    output logic             rx_req_o,
    output logic             acc_rdy_o,
    output logic             overrun_o,
    output logic             underflow_o,
    output logic             busy_o,
    output logic             txb_valid_o,
    input  logic             txb_ready_i,
    output logic [7:0]       txb_data_o,
    input  logic             rxb_valid_i,
    output logic             rxb_ready_o,
    input  logic [7:0]       rxb_data_i
);

    xfer_dir_e  start_dir;
    xfer_dir_e  cur_dir;
    logic       launch;
    logic       busy;
    logic       multi;
    logic       last;
    logic       tx_active;
    logic       rx_active;
    logic       tx_done;
    logic       rx_done;
    byte_pair_t rx_word;

    assign start_dir = start_tx_i ? XFER_TX : XFER_RX;
    assign tx_active = busy && (cur_dir == XFER_TX);
    assign rx_active = busy && (cur_dir == XFER_RX);

    i2cbp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dir_i       (start_dir),
        .count_i     (count_i),
        .byte_done_i (tx_done || rx_done),
        .launch_o    (launch),
        .busy_o      (busy),
        .dir_o       (cur_dir),
        .multi_o     (multi),
        .last_o      (last),
        .ardy_o      (acc_rdy_o)
    );

    i2cbp_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (launch),
        .launch_tx_i (start_dir == XFER_TX),
        .active_i    (tx_active),
        .multi_i     (multi),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (byte_pair_t'(wr_data_i)),
        .sh_ready_i  (txb_ready_i),
        .sh_valid_o  (txb_valid_o),
        .sh_byte_o   (txb_data_o),
        .xrdy_o      (tx_req_o),
        .udf_o       (underflow_o),
        .done_o      (tx_done)
    );

    i2cbp_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (launch),
        .active_i    (rx_active),
        .last_i      (last),
        .sh_valid_i  (rxb_valid_i),
        .sh_byte_i   (rxb_data_i),
        .rd_en_i     (rd_en_i),
        .sh_ready_o  (rxb_ready_o),
        .rd_word_o   (rx_word),
        .rrdy_o      (rx_req_o),
        .ovr_o       (overrun_o),
        .done_o      (rx_done)
    );

    assign rd_data_o = rx_word;
    assign busy_o    = busy;

    // R11: the two byte paths are never both busy
    a_r11_one_path: assert property (@(posedge clk) disable iff (rst)
        !(tx_done && rx_done));

endmodule

// File: tb/test_i2cbp_buffer.sv
module test_i2cbp_buffer;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          start_tx_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          wr_en_i = 1'b0;
    logic [15:0]   wr_data_i = '0;
    logic          rd_en_i = 1'b0;
    logic [15:0]   rd_data_o;
    logic          tx_req_o, rx_req_o, acc_rdy_o, overrun_o, underflow_o, busy_o;
    logic          txb_valid_o;
    logic          txb_ready_i = 1'b0;
    logic [7:0]    txb_data_o;
    logic          rxb_valid_i = 1'b0;
    logic          rxb_ready_o;
    logic [7:0]    rxb_data_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    i2cbp_buffer #(.CNT_W(CW)) i_i2cbp_buffer (
        .clk, .rst, .start_i, .start_tx_i, .count_i, .wr_en_i, .wr_data_i,
        .rd_en_i, .rd_data_o, .tx_req_o, .rx_req_o, .acc_rdy_o, .overrun_o,
        .underflow_o, .busy_o, .txb_valid_o, .txb_ready_i, .txb_data_o,
        .rxb_valid_i, .rxb_ready_o, .rxb_data_i
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int c, input int k, input int seed);
        return 8'(c * 37 + k * 53 + seed * 11 + 5);
    endfunction

    task automatic launch(input logic tx, input int c);
        start_i = 1'b1;
        start_tx_i = tx;
        count_i = CW'(c);
        tick();
        start_i = 1'b0;
    endtask

    task automatic tx_run(input int c, input int seed);
        int idx = 0;
        while (idx < c) begin
            int n;
            for (int w = 0; w < 20 && !tx_req_o; w++) tick();
            chk("R5 request before word", 32'(tx_req_o), 1);
            n = (c - idx >= 2) ? 2 : 1;
            wr_en_i = 1'b1;
            wr_data_i = {(n == 2) ? pat(c, idx + 1, seed) : 8'hA5, pat(c, idx, seed)};
            tick();
            wr_en_i = 1'b0;
            chk("R5 write clears request", 32'(tx_req_o), 0);
            txb_ready_i = 1'b1;
            for (int j = 0; j < n; j++) begin
                chk("R3 byte valid", 32'(txb_valid_o), 1);
                chk("R3 byte order", 32'(txb_data_o), 32'(pat(c, idx + j, seed)));
                tick();
            end
            txb_ready_i = 1'b0;
            idx += n;
        end
        chk("R4 no extra byte", 32'(txb_valid_o), 0);
        chk("R5 no request at end", 32'(tx_req_o), 0);
        chk("R10 busy cleared", 32'(busy_o), 0);
        chk("R10 access ready", 32'(acc_rdy_o), 1);
        chk("R9 no underflow", 32'(underflow_o), 0);
    endtask

    task automatic rx_run(input int c, input int seed);
        for (int k = 0; k < c; k++) begin
            chk("R11 ready while busy", 32'(rxb_ready_o), 1);
            rxb_valid_i = 1'b1;
            rxb_data_i = pat(c, k, seed);
            tick();
            rxb_valid_i = 1'b0;
            if (k % 2 == 1) begin
                chk("R6 word ready", 32'(rx_req_o), 1);
                chk("R6 packing", 32'(rd_data_o),
                    32'({pat(c, k, seed), pat(c, k - 1, seed)}));
            end else if (k == c - 1) begin
                chk("R7 half word ready", 32'(rx_req_o), 1);
                chk("R7 half word", 32'(rd_data_o), 32'({8'h00, pat(c, k, seed)}));
            end else begin
                chk("R6 no early request", 32'(rx_req_o), 0);
            end
            if (rx_req_o) begin
                rd_en_i = 1'b1;
                tick();
                rd_en_i = 1'b0;
                chk("R6 read clears", 32'(rx_req_o), 0);
            end
        end
        chk("R10 rx busy cleared", 32'(busy_o), 0);
        chk("R10 rx access ready", 32'(acc_rdy_o), 1);
        chk("R8 no overrun", 32'(overrun_o), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 flags", 32'({tx_req_o, rx_req_o, acc_rdy_o, overrun_o, underflow_o}), 0);
        chk("R1 byte sides", 32'({txb_valid_o, rxb_ready_o}), 0);
        chk("R1 data", 32'(rd_data_o), 0);

        // R2: zero count ignored
        launch(1'b1, 0);
        chk("R2 zero count busy", 32'(busy_o), 0);
        chk("R2 zero count request", 32'(tx_req_o), 0);

        // R11: idle receive ignored
        rxb_valid_i = 1'b1;
        rxb_data_i = 8'h3C;
        tick();
        rxb_valid_i = 1'b0;
        chk("R11 idle ready low", 32'(rxb_ready_o), 0);
        chk("R11 idle no request", 32'(rx_req_o), 0);
        chk("R11 idle data", 32'(rd_data_o), 0);

        // Sweeps in both directions
        for (int c = 1; c <= 12; c++) begin
            launch(1'b1, c);
            chk("R2 start busy", 32'(busy_o), 1);
            chk("R12 access ready cleared", 32'(acc_rdy_o), 0);
            tx_run(c, 1);
        end
        for (int c = 1; c <= 12; c++) begin
            launch(1'b0, c);
            chk("R2 rx start busy", 32'(busy_o), 1);
            rx_run(c, 2);
        end

        // R5 ignored write, R2 start while busy ignored
        launch(1'b1, 4);
        wr_en_i = 1'b1;
        wr_data_i = 16'h2211;
        tick();
        wr_data_i = 16'hEEDD;
        tick();
        wr_en_i = 1'b0;
        launch(1'b0, 1);
        chk("R2 busy start ignored", 32'(txb_valid_o), 1);
        txb_ready_i = 1'b1;
        chk("R5 ignored write byte0", 32'(txb_data_o), 32'h11);
        tick();
        chk("R5 ignored write byte1", 32'(txb_data_o), 32'h22);
        tick();
        txb_ready_i = 1'b0;
        chk("R5 request after word", 32'(tx_req_o), 1);
        // R9 underflow: shifter asks with no word
        txb_ready_i = 1'b1;
        tick();
        txb_ready_i = 1'b0;
        chk("R9 underflow set", 32'(underflow_o), 1);
        wr_en_i = 1'b1;
        wr_data_i = 16'h4433;
        tick();
        wr_en_i = 1'b0;
        txb_ready_i = 1'b1;
        repeat (2) tick();
        txb_ready_i = 1'b0;
        chk("R10 done after underflow", 32'(busy_o), 0);
        chk("R9 underflow sticky", 32'(underflow_o), 1);
        launch(1'b1, 1);
        chk("R12 underflow cleared", 32'(underflow_o), 0);
        tx_run(1, 3);

        // R8 overrun with no reads
        launch(1'b0, 4);
        for (int k = 0; k < 4; k++) begin
            rxb_valid_i = 1'b1;
            rxb_data_i = pat(4, k, 7);
            tick();
        end
        rxb_valid_i = 1'b0;
        held = {pat(4, 1, 7), pat(4, 0, 7)};
        chk("R8 overrun set", 32'(overrun_o), 1);
        chk("R8 first word kept", 32'(rd_data_o), 32'(held));
        chk("R8 request stays", 32'(rx_req_o), 1);
        launch(1'b0, 1);
        chk("R12 overrun cleared", 32'(overrun_o), 0);
        chk("R12 request cleared", 32'(rx_req_o), 0);
        rx_run(1, 9);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule